// File: doc/BRIEF.md
# Atomic read-modify-write unit

This unit sits next to a single-port memory. It carries out one atomic read-modify-write on a 32-bit or 64-bit word. The word's address is a destination base value plus a sign-extended 16-bit offset. The operation selector arrives in an immediate field. A source value supplies the operand, and an R0 value supplies the comparand for compare-exchange. The unit reads the word, computes the new value and, where the operation calls for it, writes the word back. The memory stays locked for the whole sequence.

When the operation asks for it, the unit also returns the old memory value. The value goes back to src for fetching operations and exchange, and to R0 for compare-exchange. An operation code the unit does not recognise ends the sequence at once. The unit then raises an error flag and issues no memory request.

Top module: `atomic_rmw_unit`

## Requirements
- R1: The memory address is `dst_i` plus `off_i` sign-extended to the address width, and it is held on `mem_addr_o` for both the read and the write.
- R2: The operation comes from `imm_i[7:4]`: 0x0 adds, 0x4 ORs, 0x5 ANDs and 0xa XORs `src_i` into the memory word. All arithmetic wraps modulo the word size.
- R3: `imm_i[0]` is the fetch flag. With it set on add, or, and, xor or exchange, `src_wb_o` pulses with `done_o`, and `src_val_o` holds the memory value from before the update.
- R4: Code 0xe with fetch set (imm 0xe1) writes `src_i` to memory and returns the old value through `src_wb_o`/`src_val_o`.
- R5: Code 0xf with fetch set (imm 0xf1) compares the memory word with `r0_i`. On equality it writes `src_i`; otherwise it skips the write. In both cases `r0_wb_o` pulses with `done_o`, `r0_val_o` holds the old value, and `src_wb_o` stays low.
- R6: With `wide_i` low, only the low 32 bits of operands and memory take part, including the comparison. Returned values and written data are zero-extended. `mem_wide_o` is low for the access.
- R7: The write request follows the read request. `lock_o` is high for every cycle in which a request is outstanding and between the read and the write. A request is held stable until `mem_ready_i`.
- R8: Any immediate other than 0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xa0, 0xa1, 0xe1 or 0xf1 completes with `err_o` and `done_o`. It makes no memory request and pulses no write-back.
- R9: `done_o` is a single-cycle pulse. `busy_o` is high from the accepting edge until the cycle after `done_o`, and `req_valid_i` is ignored while `busy_o` is high.
- R10: After reset the unit is idle: `busy_o`, `lock_o`, `mem_req_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start an operation (taken when idle) |
| imm_i | input | IMM_W | Operation selector and fetch flag |
| wide_i | input | 1 | 1 = 64-bit word, 0 = 32-bit word |
| dst_i | input | ADDR_W | Base address value |
| off_i | input | OFF_W | Signed address offset |
| src_i | input | DATA_W | Source operand |
| r0_i | input | DATA_W | Comparand for compare-exchange |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Unknown operation (valid with done_o) |
| src_wb_o | output | 1 | Write src_val_o back to src |
| src_val_o | output | DATA_W | Old memory value for src |
| r0_wb_o | output | 1 | Write r0_val_o back to R0 |
| r0_val_o | output | DATA_W | Old memory value for R0 |
| lock_o | output | 1 | Memory locked for the sequence |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_wide_o | output | 1 | Request is 64 bits wide |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Memory accepts/answers the request |
| mem_rdata_i | input | DATA_W | Read data |

## Verification
The bound checker holds the protocol invariants on every cycle. It checks that lock covers every request and that a request stays stable while stalled. It checks that done is a one-cycle pulse, that the two write-backs never coincide and never appear outside done, and that an error completion follows a cycle with no memory request. The arithmetic results are a matter for the bench's scenarios: wrap-around, the 32-bit masking and zero extension, the compare-exchange hit and miss, and the negative offset. The same holds for the immunity to a second request while busy and for the absence of any memory access on an unknown code.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_WRITE,
    ST_DONE
  } state_e;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_OR,
    OP_AND,
    OP_XOR,
    OP_XCHG,
    OP_CAS
  } op_e;

  localparam logic [3:0] CODE_ADD  = 4'h0;
  localparam logic [3:0] CODE_OR   = 4'h4;
  localparam logic [3:0] CODE_AND  = 4'h5;
  localparam logic [3:0] CODE_XOR  = 4'ha;
  localparam logic [3:0] CODE_XCHG = 4'he;
  localparam logic [3:0] CODE_CAS  = 4'hf;

endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
  import atomic_rmw_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [IMM_W-1:0] imm_i,
  output op_e              op_o,
  output logic             fetch_o,
  output logic             valid_o
);

  logic clean;

  // only the code nibble and the fetch bit may be non-zero
  assign clean   = (imm_i[IMM_W-1:8] == '0) && (imm_i[3:1] == 3'b000);
  assign fetch_o = imm_i[0];

  always_comb begin
    op_o    = OP_ADD;
    valid_o = 1'b0;
    unique case (imm_i[7:4])
      CODE_ADD:  begin op_o = OP_ADD;  valid_o = clean; end
      CODE_OR:   begin op_o = OP_OR;   valid_o = clean; end
      CODE_AND:  begin op_o = OP_AND;  valid_o = clean; end
      CODE_XOR:  begin op_o = OP_XOR;  valid_o = clean; end
      CODE_XCHG: begin op_o = OP_XCHG; valid_o = clean & imm_i[0]; end
      CODE_CAS:  begin op_o = OP_CAS;  valid_o = clean & imm_i[0]; end
      default:   begin op_o = OP_ADD;  valid_o = 1'b0; end
    endcase
  end

endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  op_e               op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] r0_i,
  output logic [DATA_W-1:0] new_o,
  output logic              match_o
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] src_m;
  logic [DATA_W-1:0] r0_m;
  logic [DATA_W-1:0] raw;

  assign lane_mask = wide_i ? '1 : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  assign src_m     = src_i & lane_mask;
  assign r0_m      = r0_i & lane_mask;

  always_comb begin
    unique case (op_i)
      OP_ADD:  raw = old_i + src_m;
      OP_OR:   raw = old_i | src_m;
      OP_AND:  raw = old_i & src_m;
      OP_XOR:  raw = old_i ^ src_m;
      OP_XCHG: raw = src_m;
      OP_CAS:  raw = src_m;
      default: raw = old_i;
    endcase
  end

  // narrow results wrap inside the low lane
  assign new_o   = raw & lane_mask;
  assign match_o = ((old_i & lane_mask) == r0_m);

endmodule

// File: rtl/atomic_rmw_seq.sv
module atomic_rmw_seq
  import atomic_rmw_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   op_ok_i,
  input  logic   mem_ready_i,
  input  logic   wr_needed_i,
  output state_e state_o
);

  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = op_ok_i ? ST_READ : ST_DONE;
      ST_READ:  if (mem_ready_i) state_d = ST_CALC;
      ST_CALC:  state_d = wr_needed_i ? ST_WRITE : ST_DONE;
      ST_WRITE: if (mem_ready_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] r0_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              src_wb_o,
  output logic [DATA_W-1:0] src_val_o,
  output logic              r0_wb_o,
  output logic [DATA_W-1:0] r0_val_o,
  output logic              lock_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_wide_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = ADDR_W - OFF_W;

  state_e state;
  op_e    dec_op, op_q;
  logic   dec_fetch, dec_ok, fetch_q, wide_q, err_q;
  logic   start, wr_needed, alu_match;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, r0_q, old_q, new_q, alu_new, rd_val;

  assign start = req_valid_i && (state == ST_IDLE);

  atomic_rmw_decode #(.IMM_W(IMM_W)) u_decode (
    .imm_i   (imm_i),
    .op_o    (dec_op),
    .fetch_o (dec_fetch),
    .valid_o (dec_ok)
  );

  atomic_rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (op_q),
    .wide_i  (wide_q),
    .old_i   (old_q),
    .src_i   (src_q),
    .r0_i    (r0_q),
    .new_o   (alu_new),
    .match_o (alu_match)
  );

  assign wr_needed = (op_q != OP_CAS) || alu_match;

  atomic_rmw_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .op_ok_i     (dec_ok),
    .mem_ready_i (mem_ready_i),
    .wr_needed_i (wr_needed),
    .state_o     (state)
  );

  assign rd_val = wide_q ? mem_rdata_i
                         : {{(DATA_W-HALF_W){1'b0}}, mem_rdata_i[HALF_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_ADD;
      fetch_q <= 1'b0;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
      new_q   <= '0;
    end else begin
      if (start) begin
        op_q    <= dec_op;
        fetch_q <= dec_fetch;
        wide_q  <= wide_i;
        err_q   <= !dec_ok;
        addr_q  <= dst_i + {{EXT_W{off_i[OFF_W-1]}}, off_i};
        src_q   <= src_i;
        r0_q    <= r0_i;
      end
      if (state == ST_READ && mem_ready_i) old_q <= rd_val;
      if (state == ST_CALC) new_q <= alu_new;
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign lock_o      = (state == ST_READ) || (state == ST_CALC) || (state == ST_WRITE);
  assign mem_req_o   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we_o    = (state == ST_WRITE);
  assign mem_wide_o  = wide_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = new_q;

  assign done_o    = (state == ST_DONE);
  assign err_o     = done_o && err_q;
  assign src_wb_o  = done_o && !err_q && fetch_q && (op_q != OP_CAS);
  assign r0_wb_o   = done_o && !err_q && (op_q == OP_CAS);
  assign src_val_o = old_q;
  assign r0_val_o  = old_q;

endmodule

// File: rtl/atomic_rmw_unit_chk.sv
module atomic_rmw_unit_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              src_wb_o,
  input logic              r0_wb_o,
  input logic              lock_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ready_i
);

  a_r7_lock_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> lock_o);

  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r7_write_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> $past(lock_o));

  a_r8_err_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> !$past(mem_req_o) && !src_wb_o && !r0_wb_o);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_lock_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> busy_o);

  a_r5_wb_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({src_wb_o, r0_wb_o}));

  a_r3_wb_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_wb_o || r0_wb_o) |-> done_o);

endmodule

bind atomic_rmw_unit atomic_rmw_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/atomic_rmw_unit_tb_top.sv
`timescale 1ns/1ps
module atomic_rmw_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] imm = '0;
  logic        wide = 1'b1;
  logic [63:0] dst = 64'h100;
  logic [15:0] off = '0;
  logic [63:0] src = '0, r0 = '0;
  logic        busy, done, err, src_wb, r0_wb, lock, mem_req, mem_we, mem_wide;
  logic [63:0] src_val, r0_val, mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #2 clk = ~clk;

  atomic_rmw_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .imm_i(imm),
    .wide_i(wide), .dst_i(dst), .off_i(off), .src_i(src), .r0_i(r0),
    .busy_o(busy), .done_o(done), .err_o(err), .src_wb_o(src_wb),
    .src_val_o(src_val), .r0_wb_o(r0_wb), .r0_val_o(r0_val), .lock_o(lock),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata)
  );

  // memory model: 16 slots of 64 bits, slot = addr[6:3]
  logic [63:0] mem [16];
  int          lat = 0, wcnt = 0, req_cnt = 0, lock_bad = 0;
  logic [63:0] last_addr = '0;
  logic        last_wide = 1'b1;

  always @(negedge clk) begin
    mem_ready <= 1'b0;
    if (mem_req) begin
      if (!lock) lock_bad++;
      if (wcnt == lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= mem[mem_addr[6:3]];
        last_addr = mem_addr;
        last_wide = mem_wide;
        req_cnt++;
        if (mem_we) begin
          if (mem_wide) mem[mem_addr[6:3]] = mem_wdata;
          else          mem[mem_addr[6:3]][31:0] = mem_wdata[31:0];
        end
        wcnt = 0;
      end else wcnt++;
    end
  end

  int checks = 0, failures = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]  imm;
    logic        wide;
    logic [15:0] off;
    logic [63:0] init;
    logic [63:0] src;
    logic [63:0] r0;
    logic [63:0] exp_mem;
    logic        exp_swb;
    logic [63:0] exp_src;
    logic        exp_rwb;
    logic [63:0] exp_r0;
    logic        exp_err;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R2 add
    '{8'h00, 1'b1, 16'h0008, 64'h10, 64'h5, 64'h0, 64'h15, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 4'd2},
    // R3 add fetch, 64-bit wrap
    '{8'h01, 1'b1, 16'h0010, 64'hFFFFFFFF_FFFFFFFF, 64'h2, 64'h0, 64'h1, 1'b1, 64'hFFFFFFFF_FFFFFFFF, 1'b0, 64'h0, 1'b0, 4'd3},
    // R6 32-bit add fetch, wrap, upper half kept
    '{8'h01, 1'b0, 16'h0018, 64'hAAAAAAAA_FFFFFFFE, 64'h3, 64'h0, 64'hAAAAAAAA_00000001, 1'b1, 64'h00000000_FFFFFFFE, 1'b0, 64'h0, 1'b0, 4'd6},
    // R2 or
    '{8'h40, 1'b1, 16'h0000, 64'hF0, 64'h0F, 64'h0, 64'hFF, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 4'd2},
    // R1 negative offset, and fetch
    '{8'h51, 1'b1, 16'hFFF8, 64'hFF00, 64'h0FF0, 64'h0, 64'h0F00, 1'b1, 64'hFF00, 1'b0, 64'h0, 1'b0, 4'd1},
    // R6 32-bit xor
    '{8'hA0, 1'b0, 16'h0020, 64'h12345678_0000FFFF, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 64'h12345678_FFFF0000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 4'd6},
    // R4 exchange
    '{8'hE1, 1'b1, 16'h0028, 64'h1111, 64'h2222, 64'h0, 64'h2222, 1'b1, 64'h1111, 1'b0, 64'h0, 1'b0, 4'd4},
    // R5 compare-exchange hit
    '{8'hF1, 1'b1, 16'h0030, 64'h55, 64'h99, 64'h55, 64'h99, 1'b0, 64'h0, 1'b1, 64'h55, 1'b0, 4'd5},
    // R5 compare-exchange miss
    '{8'hF1, 1'b1, 16'h0030, 64'h55, 64'h99, 64'h56, 64'h55, 1'b0, 64'h0, 1'b1, 64'h55, 1'b0, 4'd5},
    // R6 32-bit compare ignores upper halves
    '{8'hF1, 1'b0, 16'h0038, 64'hDEADBEEF_00000007, 64'h8, 64'hFFFFFFFF_00000007, 64'hDEADBEEF_00000008, 1'b0, 64'h0, 1'b1, 64'h7, 1'b0, 4'd6},
    // R8 unknown code
    '{8'h30, 1'b1, 16'h0040, 64'h77, 64'h1, 64'h0, 64'h77, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 4'd8},
    // R8 exchange without fetch
    '{8'hE0, 1'b1, 16'h0048, 64'h77, 64'h1, 64'h0, 64'h77, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 4'd8},
    // R8 stray immediate bit
    '{8'h02, 1'b1, 16'h0050, 64'h77, 64'h1, 64'h0, 64'h77, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 4'd8},
    // R2 xor fetch
    '{8'hA1, 1'b1, 16'h0058, 64'h0F0F, 64'hFFFF, 64'h0, 64'hF0F0, 1'b1, 64'h0F0F, 1'b0, 64'h0, 1'b0, 4'd2}
  };

  task automatic issue(input logic [31:0] i_imm, input logic i_wide, input logic [15:0] i_off,
                       input logic [63:0] i_src, input logic [63:0] i_r0);
    @(negedge clk);
    imm = i_imm; wide = i_wide; off = i_off; src = i_src; r0 = i_r0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 200; n++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin : wdog
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ok;
    for (int k = 0; k < 16; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", {63'b0, busy}, 64'h0);
    chk("R10 lock", {63'b0, lock}, 64'h0);
    chk("R10 mem_req", {63'b0, mem_req}, 64'h0);
    chk("R10 done", {63'b0, done}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [63:0] ea;
      ea = 64'h100 + {{48{VECS[v].off[15]}}, VECS[v].off};
      mem[ea[6:3]] = VECS[v].init;
      lat = v % 3;
      req_cnt = 0;
      lock_bad = 0;
      issue({24'h0, VECS[v].imm}, VECS[v].wide, VECS[v].off, VECS[v].src, VECS[v].r0);
      wait_done(ok);
      chk($sformatf("R9 vec%0d done seen", v), {63'b0, ok}, 64'h1);
      chk($sformatf("R%0d vec%0d err", VECS[v].tag, v), {63'b0, err}, {63'b0, VECS[v].exp_err});
      chk($sformatf("R%0d vec%0d src_wb", VECS[v].tag, v), {63'b0, src_wb}, {63'b0, VECS[v].exp_swb});
      chk($sformatf("R%0d vec%0d r0_wb", VECS[v].tag, v), {63'b0, r0_wb}, {63'b0, VECS[v].exp_rwb});
      if (VECS[v].exp_swb) chk($sformatf("R3 vec%0d src_val", v), src_val, VECS[v].exp_src);
      if (VECS[v].exp_rwb) chk($sformatf("R5 vec%0d r0_val", v), r0_val, VECS[v].exp_r0);
      @(negedge clk);
      chk($sformatf("R9 vec%0d done one cycle", v), {63'b0, done}, 64'h0);
      chk($sformatf("R%0d vec%0d memory", VECS[v].tag, v), mem[ea[6:3]], VECS[v].exp_mem);
      chk($sformatf("R7 vec%0d lock during requests", v), 64'(lock_bad), 64'h0);
      if (VECS[v].exp_err) begin
        chk($sformatf("R8 vec%0d no memory access", v), 64'(req_cnt), 64'h0);
      end else begin
        chk($sformatf("R1 vec%0d address", v), last_addr, ea);
        chk($sformatf("R6 vec%0d access width", v), {63'b0, last_wide}, {63'b0, VECS[v].wide});
        // R5 miss: read only; others read and write
        chk($sformatf("R7 vec%0d request count", v), 64'(req_cnt),
            (VECS[v].imm == 8'hF1 && VECS[v].exp_mem == VECS[v].init) ? 64'd1 : 64'd2);
      end
    end

    // R9 second request while busy is ignored
    mem[12] = 64'h0;
    lat = 4;
    issue(32'h00, 1'b1, 16'h0060, 64'h1, 64'h0);
    chk("R9 busy after accept", {63'b0, busy}, 64'h1);
    issue(32'h00, 1'b1, 16'h0060, 64'h64, 64'h0);
    wait_done(ok);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9 ignored request", mem[12], 64'h1);
    chk("R9 idle after done", {63'b0, busy}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule